// File: doc/BRIEF.md
# Incremental Displacement Counter

This block turns the pulse stream of an incremental position sensor into a signed running position. The two sensor lines can carry either separate up and down pulses or a two-phase quadrature pair; a static mode input chooses which. The lines enter the system clock domain through two-flop synchronizers. Each accepted movement step adds or subtracts one from a 28-bit two's-complement counter, which wraps at its ends.

A count reset loads the counter with 160 rather than zero. A sample strobe copies the live count into a holding register that a host can read while counting continues. Both the reset and the sample can come from an external active-low line, which acts once on each falling edge, or from a single-cycle host write strobe.

A zero-speed flag rises when no count has entered the counter for a programmable number of milliseconds. The timeout is 1 to 127 ms, taken from a 7-bit input, and a value of 0 is treated as 1. In quadrature mode, a step in which both phases change at once is not counted and sets a sticky error bit.

Top module: `disp_counter`

## Requirements
- R1: While `rst_n` is low, and after it returns high, `countOut` is 160, `sampleOut` is 0, and `zeroSpeed` and `quadError` are 0.
- R2: With `modeQuad`=0, a rising edge on `chA` increments the count and a rising edge on `chB` decrements it. Rising edges on both that are detected in the same cycle leave the count unchanged. Falling edges do nothing. The new count appears at the third rising clock edge, counting the first edge that samples the input change.
- R3: With `modeQuad`=1 the phase state is {chA,chB}. The sequence 00→01→11→10→00 counts +1 per step, and the reverse sequence counts −1 per step. A step appears with the same three-edge latency as in R2.
- R4: With `modeQuad`=1, a change of both phases between two synchronized samples (00↔11, 01↔10) leaves the count unchanged and sets `quadError`. `quadError` stays set until a count reset clears it.
- R5: The counter is 28 bits and wraps: decrementing 0 gives 0xFFFFFFF, and incrementing 0xFFFFFFF gives 0.
- R6: A count reset loads 160. A `hostReset` high at a clock edge acts at that edge. A falling edge of `extResetN` acts once, at the third clock edge, however long the line stays low. A reset wins over a count event at the same edge.
- R7: A `hostSample` high at an edge, or a falling edge of `extSampleN` (once, at the third edge), copies the count held before that edge into `sampleOut`. A count event at the same edge still updates the counter. At all other times `sampleOut` holds its value.
- R8: `zeroSpeed` rises exactly max(`timeoutMs`,1)×`TICKS_PER_MS` clock cycles after the edge of the last count event. It returns low at the edge of the next count event.
- R9: `timeoutMs`=0 gives the same timeout as `timeoutMs`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| modeQuad | input | 1 | 0: up/down pulses, 1: A/B quadrature |
| chA | input | 1 | Up pulse, or phase A |
| chB | input | 1 | Down pulse, or phase B |
| extResetN | input | 1 | External count reset, active low, asynchronous |
| extSampleN | input | 1 | External sample request, active low, asynchronous |
| hostReset | input | 1 | Host count reset strobe, one cycle |
| hostSample | input | 1 | Host sample strobe, one cycle |
| timeoutMs | input | 7 | Zero-speed timeout in milliseconds |
| countOut | output | 28 | Live position count |
| sampleOut | output | 28 | Sampled position count |
| zeroSpeed | output | 1 | No count within the timeout window |
| quadError | output | 1 | Sticky illegal quadrature transition flag |

## Verification
A change on a sensor line or an external strobe takes effect at the third rising edge after it is driven: two synchronizer stages, then the edge detector's registered previous value. Host strobes take effect at the edge that samples them. `zeroSpeed` is due max(`timeoutMs`,1)×`TICKS_PER_MS` edges after the count edge. The bench drives inputs on falling edges and counts exactly those rising edges before it checks at the next falling edge. The zero-speed checks look one cycle before and at the due edge, so that an off-by-one error is caught. The quadrature test sweeps every pair of previous and next phase states, and the expected delta is computed from the difference of Gray indices modulo four.

// File: rtl/dispcnt_pkg.sv
package dispcnt_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic countUp;
    logic countDown;
    logic loadInit;
    logic takeSample;
    logic quadIllegal;
  } strobe_t;

  // Map a quadrature phase pair {a,b} onto its position in the 4-step cycle.
  function automatic logic [1:0] phaseIndex(input logic a, input logic b);
    return {a, a ^ b};
  endfunction

endpackage

// File: rtl/dispcnt_sync.sv
module dispcnt_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] now,
  output logic [W-1:0] prev
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_line
      logic stage1, stage2, stage3;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage1 <= RST_VAL[i];
          stage2 <= RST_VAL[i];
          stage3 <= RST_VAL[i];
        end else begin
          stage1 <= din[i];
          stage2 <= stage1;
          stage3 <= stage2;
        end
      end
      assign now[i]  = stage2;
      assign prev[i] = stage3;
    end
  endgenerate

endmodule

// File: rtl/dispcnt_ctrl.sv
module dispcnt_ctrl
  import dispcnt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    modeQuad,
  input  logic    chA,
  input  logic    chB,
  input  logic    extResetN,
  input  logic    extSampleN,
  input  logic    hostReset,
  input  logic    hostSample,
  output strobe_t str
);

  localparam int NLINES = 4;
  // Line order: 0 chA, 1 chB, 2 extResetN, 3 extSampleN. Strobe lines idle high.
  localparam logic [NLINES-1:0] IDLE = 4'b1100;

  logic [NLINES-1:0] lineNow, linePrev;

  dispcnt_sync #(.W(NLINES), .RST_VAL(IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({extSampleN, extResetN, chB, chA}),
    .now  (lineNow),
    .prev (linePrev)
  );

  logic upRise, downRise, resetFall, sampleFall;
  logic [1:0] idxNow, idxPrev, idxStep;

  assign upRise     = lineNow[0] & ~linePrev[0];
  assign downRise   = lineNow[1] & ~linePrev[1];
  assign resetFall  = linePrev[2] & ~lineNow[2];
  assign sampleFall = linePrev[3] & ~lineNow[3];

  assign idxNow  = phaseIndex(lineNow[0], lineNow[1]);
  assign idxPrev = phaseIndex(linePrev[0], linePrev[1]);
  assign idxStep = idxNow - idxPrev;

  always_comb begin
    str = '0;
    if (modeQuad) begin
      unique case (idxStep)
        2'd1:    str.countUp     = 1'b1;
        2'd3:    str.countDown   = 1'b1;
        2'd2:    str.quadIllegal = 1'b1;
        default: ;
      endcase
    end else begin
      str.countUp   = upRise & ~downRise;
      str.countDown = downRise & ~upRise;
    end
    str.loadInit   = hostReset | resetFall;
    str.takeSample = hostSample | sampleFall;
  end

  // R2 / R3: never count both ways at once
  assert_oneDirection_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({str.countUp, str.countDown}));

  // R4: an illegal transition produces no count
  assert_illegalNoCount_R4: assert property (@(posedge clk) disable iff (!rst_n)
    str.quadIllegal |-> !(str.countUp || str.countDown));

  // R6: an external reset assertion yields a single-cycle request
  assert_resetOnce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resetFall |=> !resetFall);

  // R7: an external sample assertion yields a single-cycle request
  assert_sampleOnce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sampleFall |=> !sampleFall);

endmodule

// File: rtl/dispcnt_datapath.sv
module dispcnt_datapath
  import dispcnt_pkg::*;
#(
  parameter int             CNT_W        = 28,
  parameter logic [CNT_W-1:0] INIT_VAL   = 28'd160,
  parameter int             TICKS_PER_MS = 100000,
  parameter int             TMO_W        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          str,
  input  logic [TMO_W-1:0] timeoutMs,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] sampleOut,
  output logic             zeroSpeed,
  output logic             quadError
);

  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic countEvent;
  assign countEvent = str.countUp | str.countDown;

  // Position counter, sample register and sticky error flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countOut  <= INIT_VAL;
      sampleOut <= '0;
      quadError <= 1'b0;
    end else begin
      if (str.takeSample) sampleOut <= countOut;
      if (str.loadInit) begin
        countOut  <= INIT_VAL;
        quadError <= 1'b0;
      end else begin
        if (str.countUp)     countOut  <= countOut + 1'b1;
        if (str.countDown)   countOut  <= countOut - 1'b1;
        if (str.quadIllegal) quadError <= 1'b1;
      end
    end
  end

  // No-motion timer: prescaled millisecond count since the last count event
  logic [PRE_W-1:0] prescale;
  logic [TMO_W:0]   msCount, msNext, msLimit;

  assign msLimit = (timeoutMs == '0) ? (TMO_W+1)'(1) : {1'b0, timeoutMs};
  assign msNext  = msCount + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale  <= '0;
      msCount   <= '0;
      zeroSpeed <= 1'b0;
    end else if (countEvent) begin
      prescale  <= '0;
      msCount   <= '0;
      zeroSpeed <= 1'b0;
    end else if (prescale == PRE_LAST) begin
      prescale <= '0;
      if (!zeroSpeed) begin
        msCount <= msNext;
        if (msNext >= msLimit) zeroSpeed <= 1'b1;
      end
    end else begin
      prescale <= prescale + 1'b1;
    end
  end

  // R2 / R5: an increment adds one modulo 2^CNT_W
  assert_incWrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (str.countUp && !str.loadInit) |=> countOut == CNT_W'($past(countOut) + 1'b1));

  // R2 / R5: a decrement subtracts one modulo 2^CNT_W
  assert_decWrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (str.countDown && !str.loadInit) |=> countOut == CNT_W'($past(countOut) - 1'b1));

  // R6: a reset request loads the initial value
  assert_loadInit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    str.loadInit |=> (countOut == INIT_VAL) && !quadError);

  // R7: the sample register moves only on a sample request
  assert_sampleHold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !str.takeSample |=> $stable(sampleOut));

  // R4: the error flag is sticky until a count reset
  assert_errSticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (quadError && !str.loadInit) |=> quadError);

  // R8: a count event clears the zero-speed flag
  assert_zsClear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    countEvent |=> !zeroSpeed);

  // R8: the flag rises only on a millisecond boundary
  assert_zsOnTick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zeroSpeed) |-> prescale == '0);

endmodule

// File: rtl/disp_counter.sv
module disp_counter
  import dispcnt_pkg::*;
#(
  parameter int               CNT_W        = 28,
  parameter logic [CNT_W-1:0] INIT_VAL     = 28'd160,
  parameter int               TICKS_PER_MS = 100000,
  parameter int               TMO_W        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modeQuad,
  input  logic             chA,
  input  logic             chB,
  input  logic             extResetN,
  input  logic             extSampleN,
  input  logic             hostReset,
  input  logic             hostSample,
  input  logic [TMO_W-1:0] timeoutMs,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] sampleOut,
  output logic             zeroSpeed,
  output logic             quadError
);

  strobe_t str;

  dispcnt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .modeQuad  (modeQuad),
    .chA       (chA),
    .chB       (chB),
    .extResetN (extResetN),
    .extSampleN(extSampleN),
    .hostReset (hostReset),
    .hostSample(hostSample),
    .str       (str)
  );

  dispcnt_datapath #(
    .CNT_W       (CNT_W),
    .INIT_VAL    (INIT_VAL),
    .TICKS_PER_MS(TICKS_PER_MS),
    .TMO_W       (TMO_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .str      (str),
    .timeoutMs(timeoutMs),
    .countOut (countOut),
    .sampleOut(sampleOut),
    .zeroSpeed(zeroSpeed),
    .quadError(quadError)
  );

  // R1: reset state is observed on the first cycle out of reset
  assert_resetState_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (countOut == INIT_VAL) && (sampleOut == '0) && !quadError);

endmodule

// File: tb/sim_disp_counter.sv
module sim_disp_counter;

  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 4;
  localparam int CW         = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeQuad = 1'b0, chA = 1'b0, chB = 1'b0;
  logic extResetN = 1'b1, extSampleN = 1'b1, hostReset = 1'b0, hostSample = 1'b0;
  logic [6:0] timeoutMs = 7'd3;
  logic [CW-1:0] countOut, sampleOut;
  logic zeroSpeed, quadError;

  int vecCount = 0;
  int errCount = 0;
  bit done = 0;
  logic [CW-1:0] expCount;
  logic [CW-1:0] expSample;
  logic [1:0] curIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_counter #(.TICKS_PER_MS(TPM)) u0 (
    .clk(clk), .rst_n(rst_n), .modeQuad(modeQuad), .chA(chA), .chB(chB),
    .extResetN(extResetN), .extSampleN(extSampleN), .hostReset(hostReset),
    .hostSample(hostSample), .timeoutMs(timeoutMs), .countOut(countOut),
    .sampleOut(sampleOut), .zeroSpeed(zeroSpeed), .quadError(quadError)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive the lines at a falling edge, then wait for the third rising edge.
  task automatic driveLines(input logic a, input logic b);
    chA = a; chB = b;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic up, input logic down);
    driveLines(up, down);
    driveLines(1'b0, 1'b0);
  endtask

  task automatic hostResetPulse();
    hostReset = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostReset = 1'b0;
    expCount = 28'd160;
  endtask

  task automatic quadGo(input logic [1:0] idx);
    driveLines(idx[1], idx[1] ^ idx[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count in reset", countOut, 28'd160);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", countOut, 28'd160);
    check("R1 sample", sampleOut, 0);
    check("R1 zeroSpeed", zeroSpeed, 0);
    check("R1 quadError", quadError, 0);
    expCount = 28'd160;

    // R2: sweep of rising-edge combinations in up/down mode
    for (int c = 0; c < 4; c++) begin
      logic u, d;
      u = c[0]; d = c[1];
      driveLines(u, d);
      if (u && !d) expCount = expCount + 1'b1;
      if (d && !u) expCount = expCount - 1'b1;
      check("R2 rise combo", countOut, expCount);
      driveLines(1'b0, 1'b0);
      check("R2 falling edges ignored", countOut, expCount);
    end

    // R5: wrap through zero in both directions
    hostResetPulse();
    check("R6 host reset", countOut, 28'd160);
    for (int k = 0; k < 161; k++) pulse(1'b0, 1'b1);
    check("R5 wrap below zero", countOut, 28'hFFFFFFF);
    pulse(1'b1, 1'b0);
    check("R5 wrap above max", countOut, 0);
    expCount = 0;

    // R6: external reset acts once while the line is held low
    extResetN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expCount = 28'd160;
    check("R6 external reset", countOut, expCount);
    pulse(1'b1, 1'b0);
    expCount = expCount + 1'b1;
    check("R6 held low acts once", countOut, expCount);
    extResetN = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 release no effect", countOut, expCount);

    // R6: host reset at the same edge as a count event wins
    pulse(1'b1, 1'b0);
    chA = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    hostReset = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostReset = 1'b0;
    expCount = 28'd160;
    check("R6 reset beats count", countOut, expCount);
    driveLines(1'b0, 1'b0);

    // R7: host sample at the same edge as a count takes the earlier value
    chA = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    hostSample = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostSample = 1'b0;
    expSample = expCount;
    expCount = expCount + 1'b1;
    check("R7 sample pre-count value", sampleOut, expSample);
    check("R7 counting continues", countOut, expCount);
    driveLines(1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    expCount = expCount + 1'b1;
    check("R7 sample holds", sampleOut, expSample);
    extSampleN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 external sample", sampleOut, expCount);
    pulse(1'b0, 1'b1);
    expCount = expCount - 1'b1;
    check("R7 held low samples once", sampleOut, expCount + 1'b1);
    extSampleN = 1'b1;

    // R8: timeout of 3 ms, checked one cycle early and on time
    timeoutMs = 7'd3;
    driveLines(1'b1, 1'b0);
    expCount = expCount + 1'b1;
    check("R8 cleared on count", zeroSpeed, 0);
    chA = 1'b0;
    repeat (3*TPM - 1) @(posedge clk);
    @(negedge clk);
    check("R8 not yet", zeroSpeed, 0);
    @(posedge clk);
    @(negedge clk);
    check("R8 raised on time", zeroSpeed, 1);

    // R9: timeout of 0 behaves as 1 ms
    timeoutMs = 7'd0;
    driveLines(1'b0, 1'b1);
    expCount = expCount - 1'b1;
    check("R8 cleared by next count", zeroSpeed, 0);
    chB = 1'b0;
    repeat (TPM - 1) @(posedge clk);
    @(negedge clk);
    check("R9 not yet", zeroSpeed, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 zero treated as one", zeroSpeed, 1);
    check("R2 count after timer tests", countOut, expCount);

    // R3/R4: every pair of previous and next phase states
    modeQuad = 1'b1;
    curIdx = 2'd0;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        logic [1:0] step;
        while (curIdx != 2'(s)) begin
          curIdx = curIdx + 1'b1;
          quadGo(curIdx);
          expCount = expCount + 1'b1;
        end
        check("R3 walk", countOut, expCount);
        hostResetPulse();
        check("R4 cleared by reset", quadError, 0);
        step = 2'(t) - 2'(s);
        quadGo(2'(t));
        curIdx = 2'(t);
        if (step == 2'd1) expCount = expCount + 1'b1;
        if (step == 2'd3) expCount = expCount - 1'b1;
        check(step == 2'd2 ? "R4 illegal no count" : "R3 quad step", countOut, expCount);
        check("R4 error flag", quadError, step == 2'd2);
      end
    end
    quadGo(curIdx);
    check("R4 error sticky", quadError, (curIdx == 2'd1));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

endmodule